// File: doc/BRIEF.md
# Real-Time Clock Register Block with Backup-Domain Shadows

This block is the register front end of a real-time clock whose state lives in a slow, always-on backup domain. It holds a control register, a read-only status word, a running seconds counter, an alarm compare value, a watchdog timeout value and six persistent registers. The processor sees all of them through a 32-bit register bus. Bus writes to a backup-domain register first land in a fast-side shadow copy. The block then moves pending shadows into the backup domain one per slow-domain tick, in a fixed order. Until a register's copy has finished, a per-register stale bit is raised in the status word.

The slow domain is modelled by a tick-enable strobe, `slow_tick`. A divider turns a fixed number of these ticks into one second. On each second the backup seconds counter advances. When the new count equals the alarm value and the alarm is armed, an alarm is latched, and it stays pending until software clears it. Every register has three write views: a plain write, a set view that ORs in the written ones, and a clear view that removes them. This lets software flip single bits without a read-modify-write.

Top module: `rtc_shadow_regs`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The status word reads with bit31 = 1, bit28 = `xtal_32000_fit`, bit27 = `xtal_32768_fit`, and the stale field (bits 23:16) = 0.
- R2: A register is selected by address bits 7:4: control 0x0, status 0x1, seconds 0x3, alarm 0x4, watchdog 0x5, persistent0..5 at 0x6..0xB. Address bits 3:2 select the access: 00 writes the data, 01 ORs the data in, 10 clears the data's one-bits, and 11 has no effect. Bits that the data leaves alone keep their value. Reads of any view return the register.
- R3: In control, only bit0 (alarm interrupt enable), bit1 (millisecond interrupt enable), bit2 (alarm pending) and bit4 (watchdog enable) are writable. All other control bits read 0.
- R4: Any write access to a shadowed register sets its stale bit. The stale field has persistent0..5 at bits 16..21, alarm at bit 22 and seconds at bit 23.
- R5: On each cycle with `slow_tick` high, exactly the lowest-numbered stale register (persistent0 first, seconds last) is copied and its stale bit clears. Reads of a shadowed register return the backup value, so they return the old value until that register's copy is done.
- R6: A burst that dirties all eight shadowed registers is fully copied, with the stale field back at 0, after at most eight slow ticks.
- R7: The seconds counter advances by one on every `SLOW_PER_SEC`-th slow tick. If a seconds copy lands on the same tick, the copied value is taken and no increment happens.
- R8: When an increment makes seconds equal the alarm value while persistent0 bit2 is set, control bit2 and persistent0 bit7 are both set.
- R9: Control bit2 stays set until a control write clears it.
- R10: `irq` is high exactly when control bit2 and control bit0 are both set.
- R11: Writes to the status address have no effect.
- R12: The watchdog register takes writes at once. It has no stale bit.
- R13: A set or clear view applied to a stale register acts on its pending shadow value, so back-to-back set accesses accumulate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe marking each backup-domain tick |
| xtal_32000_fit | input | 1 | Strap: 32000 Hz crystal fitted |
| xtal_32768_fit | input | 1 | Strap: 32768 Hz crystal fitted |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address: register in 7:4, access view in 3:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Alarm interrupt |

## Verification
A wrong copy pointer or a lost stale bit shows in the status word on the very next slow tick. It also shows a tick later as an old or wrong value when the affected register is read back. A seconds counter that is off by one, or one that increments while a copy is landing, changes the read value of the seconds register at once. It also moves the alarm hit by one second, so `irq` rises a whole second early or late. A pending flag that clears by itself drops `irq` on the next cycle, with no control write to explain it.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
   localparam int unsigned DW        = 32;
   localparam int unsigned NPERS     = 6;
   localparam int unsigned NSHD      = NPERS + 2;
   localparam int unsigned IDX_ALARM = NPERS;
   localparam int unsigned IDX_SECS  = NPERS + 1;

   localparam logic [DW-1:0] CTRL_WMASK = 32'h0000_0017;
   localparam int unsigned CTRL_IRQ_EN  = 0;
   localparam int unsigned CTRL_PEND    = 2;
   localparam int unsigned P0_ALM_ARM   = 2;
   localparam int unsigned P0_WAKE_STS  = 7;

   localparam logic [3:0] SLOT_CTRL  = 4'h0;
   localparam logic [3:0] SLOT_STAT  = 4'h1;
   localparam logic [3:0] SLOT_SECS  = 4'h3;
   localparam logic [3:0] SLOT_ALARM = 4'h4;
   localparam logic [3:0] SLOT_WDOG  = 4'h5;
   localparam logic [3:0] SLOT_P0    = 4'h6;

   typedef enum logic [1:0] {
      ACC_WRITE = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLEAR = 2'd2,
      ACC_NONE  = 2'd3
   } acc_op_e;

   typedef logic [NSHD-1:0][DW-1:0] shd_word_t;

   function automatic logic [DW-1:0] apply_op(acc_op_e op, logic [DW-1:0] cur,
                                              logic [DW-1:0] wd);
      case (op)
         ACC_WRITE: return wd;
         ACC_SET:   return cur | wd;
         ACC_CLEAR: return cur & ~wd;
         default:   return cur;
      endcase
   endfunction

   function automatic logic [3:0] shadow_slot(int unsigned idx);
      if (idx < NPERS)       return SLOT_P0 + 4'(idx);
      else if (idx == IDX_ALARM) return SLOT_ALARM;
      else                   return SLOT_SECS;
   endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode
   import rtc_shadow_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output acc_op_e           op,
   output logic              sel_ctrl,
   output logic              sel_stat,
   output logic              sel_wdog,
   output logic [NSHD-1:0]   sel_shadow,
   output logic              wr_ctrl,
   output logic              wr_wdog,
   output logic [NSHD-1:0]   wr_shadow
);
   logic       in_range;
   logic       wr_act;
   logic [3:0] slot;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("rtc_bus_decode: ADDR_W must be at least 8");
      end
      if (ADDR_W > 8) begin : g_wide
         assign in_range = ~|bus_addr[ADDR_W-1:8] & ~|bus_addr[1:0];
      end else begin : g_narrow
         assign in_range = ~|bus_addr[1:0];
      end
   endgenerate

   assign slot   = bus_addr[7:4];
   assign op     = acc_op_e'(bus_addr[3:2]);
   assign wr_act = bus_wr && (op != ACC_NONE);

   assign sel_ctrl = in_range && (slot == SLOT_CTRL);
   assign sel_stat = in_range && (slot == SLOT_STAT);
   assign sel_wdog = in_range && (slot == SLOT_WDOG);
   assign wr_ctrl  = wr_act && sel_ctrl;
   assign wr_wdog  = wr_act && sel_wdog;

   generate
      for (genvar i = 0; i < NSHD; i++) begin : g_sel
         assign sel_shadow[i] = in_range && (slot == shadow_slot(i));
         assign wr_shadow[i]  = wr_act && sel_shadow[i];
      end
   endgenerate
endmodule

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
   parameter int unsigned SLOW_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_tick,
   output logic sec_strobe
);
   generate
      if (SLOW_PER_SEC < 1) begin : g_bad
         $error("rtc_sec_divider: SLOW_PER_SEC must be at least 1");
      end
      if (SLOW_PER_SEC == 1) begin : g_pass
         assign sec_strobe = slow_tick;
      end else begin : g_count
         localparam int unsigned CW = $clog2(SLOW_PER_SEC);
         localparam logic [CW-1:0] LAST = CW'(SLOW_PER_SEC - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (slow_tick)
               cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
         end
         assign sec_strobe = slow_tick && (cnt_q == LAST);
      end
   endgenerate

   AST_SEC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      sec_strobe |-> slow_tick); // R7
endmodule

// File: rtl/rtc_backup_bank.sv
module rtc_backup_bank
   import rtc_shadow_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slow_tick,
   input  logic            sec_inc,
   input  logic            alarm_evt,
   input  logic [NSHD-1:0] wr_hit,
   input  acc_op_e         op,
   input  logic [DW-1:0]   wdata,
   output shd_word_t       bkp_q,
   output logic [NSHD-1:0] stale_q,
   output logic [NSHD-1:0] copy_sel
);
   shd_word_t shadow_q;

   always_comb begin
      logic found;
      found    = 1'b0;
      copy_sel = '0;
      for (int i = 0; i < NSHD; i++) begin
         if (slow_tick && stale_q[i] && !found) begin
            copy_sel[i] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   generate
      for (genvar i = 0; i < NSHD; i++) begin : g_slice
         localparam bit IS_P0   = (i == 0);
         localparam bit IS_SECS = (i == IDX_SECS);
         logic [DW-1:0] wake_or;
         logic [DW-1:0] base;
         logic [DW-1:0] wr_val;

         assign wake_or = (IS_P0 && alarm_evt) ? (DW'(1) << P0_WAKE_STS) : '0;
         assign base    = stale_q[i] ? shadow_q[i] : bkp_q[i];
         assign wr_val  = apply_op(op, base, wdata);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               shadow_q[i] <= '0;
               bkp_q[i]    <= '0;
               stale_q[i]  <= 1'b0;
            end else begin
               shadow_q[i] <= (wr_hit[i] ? wr_val : shadow_q[i]) | wake_or;
               if (wr_hit[i])
                  stale_q[i] <= 1'b1;
               else if (copy_sel[i])
                  stale_q[i] <= 1'b0;
               if (copy_sel[i])
                  bkp_q[i] <= shadow_q[i] | wake_or;
               else if (IS_SECS && sec_inc)
                  bkp_q[i] <= bkp_q[i] + 1'b1;
               else
                  bkp_q[i] <= bkp_q[i] | wake_or;
            end
         end

         AST_STALE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (copy_sel[i] && !wr_hit[i]) |=> !stale_q[i]); // R5
      end
   endgenerate

   AST_COPY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(copy_sel)); // R5
   AST_COPY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_tick |-> (copy_sel == '0)); // R5
   AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_inc && !copy_sel[IDX_SECS]) |=>
      (bkp_q[IDX_SECS] == $past(bkp_q[IDX_SECS]) + 1'b1)); // R7
   AST_WAKE_STS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> bkp_q[0][P0_WAKE_STS]); // R8
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
   import rtc_shadow_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned SLOW_PER_SEC = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              xtal_32000_fit,
   input  logic              xtal_32768_fit,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   acc_op_e         op;
   logic            sel_ctrl, sel_stat, sel_wdog;
   logic            wr_ctrl, wr_wdog;
   logic [NSHD-1:0] sel_shadow, wr_shadow;
   logic            sec_strobe, alarm_evt;
   shd_word_t       bkp_q;
   logic [NSHD-1:0] stale_q, copy_sel;
   logic [DW-1:0]   ctrl_q, wdog_q, status_w, shd_rd;

   rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .op        (op),
      .sel_ctrl  (sel_ctrl),
      .sel_stat  (sel_stat),
      .sel_wdog  (sel_wdog),
      .sel_shadow(sel_shadow),
      .wr_ctrl   (wr_ctrl),
      .wr_wdog   (wr_wdog),
      .wr_shadow (wr_shadow)
   );

   rtc_sec_divider #(.SLOW_PER_SEC(SLOW_PER_SEC)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .sec_strobe(sec_strobe)
   );

   assign alarm_evt = sec_strobe && !copy_sel[IDX_SECS]
                   && ((bkp_q[IDX_SECS] + 32'd1) == bkp_q[IDX_ALARM])
                   && bkp_q[0][P0_ALM_ARM];

   rtc_backup_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .slow_tick(slow_tick),
      .sec_inc  (sec_strobe),
      .alarm_evt(alarm_evt),
      .wr_hit   (wr_shadow),
      .op       (op),
      .wdata    (bus_wdata),
      .bkp_q    (bkp_q),
      .stale_q  (stale_q),
      .copy_sel (copy_sel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         wdog_q <= '0;
      end else begin
         ctrl_q <= (wr_ctrl ? (apply_op(op, ctrl_q, bus_wdata) & CTRL_WMASK) : ctrl_q)
                 | (alarm_evt ? (DW'(1) << CTRL_PEND) : '0);
         if (wr_wdog)
            wdog_q <= apply_op(op, wdog_q, bus_wdata);
      end
   end

   assign status_w = {1'b1, 2'b00, xtal_32000_fit, xtal_32768_fit, 3'b000,
                      stale_q, 16'h0000};

   always_comb begin
      shd_rd = '0;
      for (int i = 0; i < NSHD; i++)
         if (sel_shadow[i]) shd_rd = bkp_q[i];
   end

   always_comb begin
      if (sel_ctrl)      bus_rdata = ctrl_q;
      else if (sel_stat) bus_rdata = status_w;
      else if (sel_wdog) bus_rdata = wdog_q;
      else               bus_rdata = shd_rd;
   end

   assign irq = ctrl_q[CTRL_PEND] & ctrl_q[CTRL_IRQ_EN];

   AST_ALARM_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> ctrl_q[CTRL_PEND]); // R8
   AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CTRL_PEND] && !(wr_ctrl && ((op == ACC_WRITE && !bus_wdata[CTRL_PEND]) ||
                                          (op == ACC_CLEAR && bus_wdata[CTRL_PEND]))))
      |=> ctrl_q[CTRL_PEND]); // R9
endmodule

// File: tb/rtc_shadow_regs_bench.sv
module rtc_shadow_regs_bench;
   localparam int SPS = 4;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        x32000 = 1'b1;
   logic        x32768 = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h10;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int    n_cmp = 0, n_bad = 0, cyc = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #5 clk = ~clk;

   rtc_shadow_regs #(.ADDR_W(8), .SLOW_PER_SEC(SPS)) u_rtc_shadow_regs (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .xtal_32000_fit(x32000), .xtal_32768_fit(x32768),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq));

   // behavioural reference: index 0..5 persistent, 6 alarm, 7 seconds
   logic [31:0] m_sh[8], m_bk[8], n_sh[8], n_bk[8];
   bit          m_st[8], n_st[8];
   logic [31:0] m_ctrl, m_wd, n_ctrl, n_wd;
   int          m_div, ci, widx, slot, op;
   bit          strb, evt;

   function automatic logic [31:0] opf(int o, logic [31:0] c, logic [31:0] d);
      if (o == 0) return d;
      if (o == 1) return c | d;
      if (o == 2) return c & ~d;
      return c;
   endfunction

   function automatic int slot_idx(int s);
      if (s >= 6 && s <= 11) return s - 6;
      if (s == 4) return 6;
      if (s == 3) return 7;
      return -1;
   endfunction

   function automatic logic [31:0] exp_rd(logic [7:0] a);
      logic [7:0] stf;
      int s;
      if (a[1:0] != 0) return 0;
      s = int'(a[7:4]);
      for (int i = 0; i < 8; i++) stf[i] = m_st[i];
      if (s == 0) return m_ctrl;
      if (s == 1) return {1'b1, 2'b00, x32000, x32768, 3'b000, stf, 16'h0};
      if (s == 5) return m_wd;
      if (slot_idx(s) >= 0) return m_bk[slot_idx(s)];
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin m_sh[i] = 0; m_bk[i] = 0; m_st[i] = 0; end
         m_ctrl = 0; m_wd = 0; m_div = 0;
      end else begin
         ci = -1;
         if (slow_tick) for (int i = 0; i < 8; i++) if (m_st[i] && ci < 0) ci = i;
         strb = 0;
         if (slow_tick) begin
            if (m_div == SPS - 1) begin m_div = 0; strb = 1; end
            else m_div = m_div + 1;
         end
         evt = strb && ci != 7 && ((m_bk[7] + 32'd1) == m_bk[6]) && m_bk[0][2];
         for (int i = 0; i < 8; i++) begin n_sh[i] = m_sh[i]; n_bk[i] = m_bk[i]; n_st[i] = m_st[i]; end
         n_ctrl = m_ctrl; n_wd = m_wd;
         if (ci >= 0) begin n_bk[ci] = m_sh[ci]; n_st[ci] = 0; end
         if (strb && ci != 7) n_bk[7] = m_bk[7] + 1;
         slot = int'(bus_addr[7:4]); op = int'(bus_addr[3:2]);
         if (bus_wr && op != 3 && bus_addr[1:0] == 0) begin
            widx = slot_idx(slot);
            if (slot == 0) n_ctrl = opf(op, m_ctrl, bus_wdata) & 32'h17;
            else if (slot == 5) n_wd = opf(op, m_wd, bus_wdata);
            else if (widx >= 0) begin
               n_sh[widx] = opf(op, m_st[widx] ? m_sh[widx] : m_bk[widx], bus_wdata);
               n_st[widx] = 1;
            end
         end
         if (evt) begin n_ctrl[2] = 1'b1; n_sh[0][7] = 1'b1; n_bk[0][7] = 1'b1; end
         for (int i = 0; i < 8; i++) begin m_sh[i] = n_sh[i]; m_bk[i] = n_bk[i]; m_st[i] = n_st[i]; end
         m_ctrl = n_ctrl; m_wd = n_wd;
      end
   end

   always @(posedge clk) begin
      #3;
      cyc = cyc + 1;
      if (!done) begin
         n_cmp = n_cmp + 1;
         if (bus_rdata !== exp_rd(bus_addr) || irq !== (m_ctrl[2] & m_ctrl[0])) begin
            n_bad = n_bad + 1;
            $display("FAIL %s addr=%h rdata=%h exp=%h irq=%b exp_irq=%b", cur_req,
                     bus_addr, bus_rdata, exp_rd(bus_addr), irq, m_ctrl[2] & m_ctrl[0]);
         end
      end
      if (cyc > 20000 && !done) begin
         n_bad = n_bad + 1;
         done = 1'b1;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (got !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic tick(logic [7:0] a);
      @(negedge clk); bus_addr = a; slow_tick = 1'b1;
      @(negedge clk); slow_tick = 1'b0;
   endtask

   task automatic peek(logic [7:0] a, output logic [31:0] v);
      @(negedge clk); bus_addr = a;
      @(posedge clk); #3; v = bus_rdata;
   endtask

   initial begin
      logic [31:0] v;
      repeat (4) @(negedge clk);
      peek(8'h10, v); chk("R1", v, 32'h9000_0000);
      rst_n = 1'b1;
      peek(8'h10, v); chk("R1", v, 32'h9000_0000);
      chk("R1", {31'd0, irq}, 32'd0);

      cur_req = "R3";
      wr(8'h00, 32'hFFFF_FFFF);
      peek(8'h00, v); chk("R3", v, 32'h17);
      cur_req = "R2";
      wr(8'h08, 32'h2); wr(8'h04, 32'h100); wr(8'h0C, 32'h0);
      peek(8'h00, v); chk("R2", v, 32'h15);
      wr(8'h00, 32'h0);

      cur_req = "R12";
      wr(8'h50, 32'h1234); wr(8'h54, 32'hF_0000); wr(8'h58, 32'h4);
      peek(8'h50, v); chk("R12", v, 32'h000F_1230);
      peek(8'h10, v); chk("R12", v, 32'h9000_0000);

      cur_req = "R11";
      wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFF_0000);
      peek(8'h10, v); chk("R11", v, 32'h9000_0000);

      cur_req = "R4";
      wr(8'h30, 32'd100); wr(8'h40, 32'd500); wr(8'hB0, 32'd5);
      wr(8'h84, 32'h1); wr(8'h84, 32'h2); wr(8'h60, 32'h4);
      peek(8'h10, v); chk("R4", v[23:16], 32'hE5);
      peek(8'h84, v); chk("R5", v, 32'h0);
      cur_req = "R5";
      for (int k = 0; k < 8; k++) tick(8'h10);
      peek(8'h10, v); chk("R6", v[23:16], 32'h0);
      cur_req = "R13";
      peek(8'h84, v); chk("R13", v, 32'h3);

      cur_req = "R6";
      for (int k = 0; k < 6; k++) wr(8'h60 + 8'(k * 16), 32'h4 | 32'(k << 8));
      wr(8'h44, 32'h0); wr(8'h38, 32'h0);
      peek(8'h10, v); chk("R6", v[23:16], 32'hFF);
      for (int k = 0; k < 8; k++) tick(8'h10);
      peek(8'h10, v); chk("R6", v[23:16], 32'h0);

      cur_req = "R8";
      wr(8'h04, 32'h1);
      wr(8'h40, 32'd103);
      for (int k = 0; k < 12; k++) tick(k[0] ? 8'h30 : 8'h00);
      peek(8'h00, v); chk("R8", v, 32'h5);
      peek(8'h60, v); chk("R8", v, 32'h84);
      chk("R10", {31'd0, irq}, 32'd1);
      cur_req = "R9";
      for (int k = 0; k < 5; k++) tick(8'h00);
      wr(8'h04, 32'h10);
      peek(8'h00, v); chk("R9", v, 32'h15);
      cur_req = "R10";
      wr(8'h08, 32'h1);
      chk("R10", {31'd0, irq}, 32'd0);
      wr(8'h08, 32'h14);
      peek(8'h00, v); chk("R9", v, 32'h0);

      cur_req = "R7";
      tick(8'h30); tick(8'h30); tick(8'h30);
      wr(8'h30, 32'd50);
      tick(8'h30);
      peek(8'h30, v); chk("R7", v, 32'd50);
      for (int k = 0; k < SPS; k++) tick(8'h30);
      peek(8'h30, v); chk("R7", v, 32'd51);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule